// File: doc/BRIEF.md
# Predicate Pattern Generator with Condition Flags

This block is the execution stage for a scalable-vector instruction that fills a predicate register from a named pattern. It takes a 2-bit element-size code, a 5-bit pattern code, a 4-bit destination predicate index and the vector length currently in force. From these it works out how many leading elements should be active. It then builds the predicate word, with one bit per vector byte, and derives four condition flags from that word.

The result, the destination index and the flags are registered. They appear one clock after the valid strobe, together with a done pulse. The register file that takes the predicate and the flags register that takes NZCV sit outside this block.

Top module: `pred_pattern_gen`

## Requirements
- R1: The element size is 8 << size bits (size code 0 = 8, 1 = 16, 2 = 32, 3 = 64). The element count is VL divided by the element size. VL is a multiple of 128 from 128 to 2048.
- R2: Element e owns predicate bits e*(esize/8) up to e*(esize/8)+esize/8-1. An active element sets only the lowest of its bits. Every other bit, and every bit at or above VL/8, reads zero.
- R3: Pattern codes 1..8 request exactly 1..8 elements. Codes 9..13 request 16, 32, 64, 128 and 256 elements. When the request fits, the leading elements are true up to that count.
- R4: A fixed-count pattern from R3 that asks for more elements than the element count gives an all-zero predicate.
- R5: Pattern 0 gives the largest power of two that is not above the element count.
- R6: Pattern 29 gives the largest multiple of 4 that is not above the element count. Pattern 30 gives the largest multiple of 3.
- R7: Pattern 31 makes every element true.
- R8: Pattern codes 14..28 give a count of zero and an all-zero predicate, and the block raises no error.
- R9: Flag N (out_nzcv bit 3) is 1 exactly when element 0 is true.
- R10: Flag Z (out_nzcv bit 2) is 1 exactly when no element is true.
- R11: Flag C (out_nzcv bit 1) is 1 exactly when the last element (index count-1) is false. Flag V (out_nzcv bit 0) is always 0.
- R12: The predicate, the flags and the destination index are updated on the first rising edge after in_valid is sampled high. out_done is high for exactly that cycle. While in_valid is low, the outputs hold their values.
- R13: While reset is asserted, and after it is released, all outputs are zero until the first valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe |
| in_size | input | 2 | Element-size code |
| in_pattern | input | 5 | Pattern code |
| in_dest | input | 4 | Destination predicate index |
| in_vl | input | 12 | Current vector length in bits |
| out_done | output | 1 | One-cycle pulse marking a new result |
| out_pred | output | 256 | Predicate word, one bit per vector byte |
| out_dest | output | 4 | Destination index of the result |
| out_nzcv | output | 4 | Flags {N, Z, C, V} |

## Verification
Each result is due on the single rising edge after the request is sampled. That covers the predicate word, every one of the four flags, the destination index and the done pulse. The bench drives a request at a falling edge, lowers the strobe at the next falling edge and compares all outputs at that point, half a period after the capturing edge. It then waits one idle cycle. At the falling edge of that cycle it checks that done has fallen and that the predicate has held.

// File: rtl/pg_pkg.sv
package pg_pkg;

  // Pattern codes whose count is not a fixed number
  localparam logic [4:0] PAT_POW2 = 5'd0;
  localparam logic [4:0] PAT_MUL4 = 5'd29;
  localparam logic [4:0] PAT_MUL3 = 5'd30;
  localparam logic [4:0] PAT_ALL  = 5'd31;

  // Last code of the fixed small counts (1..8) and of the power-of-two steps (16..256)
  localparam logic [4:0] PAT_SMALL_LAST = 5'd8;
  localparam logic [4:0] PAT_STEP_LAST  = 5'd13;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/pg_count_decode.sv
module pg_count_decode #(
  parameter int VL_MAX = 2048,
  localparam int VL_W  = $clog2(VL_MAX) + 1,
  localparam int CNT_W = $clog2(VL_MAX / 8) + 1
) (
  input  logic [1:0]       size,
  input  logic [4:0]       pattern,
  input  logic [VL_W-1:0]  vl,
  output logic [CNT_W-1:0] elems,
  output logic [CNT_W-1:0] count
);
  import pg_pkg::*;

  logic [CNT_W-1:0] fixed_req;
  logic             is_fixed;
  logic [CNT_W-1:0] pow2_cnt;

  // Number of elements at the current length
  always_comb begin
    elems = CNT_W'(vl >> (32'(size) + 3));
  end

  // Fixed request sizes
  always_comb begin
    is_fixed  = 1'b0;
    fixed_req = '0;
    if (pattern != PAT_POW2 && pattern <= PAT_SMALL_LAST) begin
      is_fixed  = 1'b1;
      fixed_req = CNT_W'(pattern);
    end else if (pattern > PAT_SMALL_LAST && pattern <= PAT_STEP_LAST) begin
      is_fixed  = 1'b1;
      fixed_req = CNT_W'(16) << (pattern - 5'd9);
    end
  end

  // Highest set bit of the element count
  always_comb begin
    pow2_cnt = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (elems[i]) pow2_cnt = CNT_W'(1) << i;
    end
  end

  always_comb begin
    if (is_fixed) begin
      count = (fixed_req <= elems) ? fixed_req : '0;
    end else begin
      unique case (pattern)
        PAT_POW2: count = pow2_cnt;
        PAT_MUL4: count = elems & ~CNT_W'(3);
        PAT_MUL3: count = elems - (elems % CNT_W'(3));
        PAT_ALL:  count = elems;
        default:  count = '0;
      endcase
    end
  end

endmodule

// File: rtl/pg_mask_build.sv
module pg_mask_build #(
  parameter int VL_MAX  = 2048,
  localparam int VL_W   = $clog2(VL_MAX) + 1,
  localparam int PRED_W = VL_MAX / 8,
  localparam int CNT_W  = $clog2(PRED_W) + 1
) (
  input  logic [1:0]        size,
  input  logic [VL_W-1:0]   vl,
  input  logic [CNT_W-1:0]  count,
  output logic [PRED_W-1:0] pred
);

  logic [CNT_W-1:0] byte_len;
  logic [CNT_W-1:0] grp_mask;

  always_comb begin
    byte_len = CNT_W'(vl >> 3);
    grp_mask = (CNT_W'(1) << size) - CNT_W'(1);
  end

  for (genvar j = 0; j < PRED_W; j++) begin : g_bit
    localparam logic [CNT_W-1:0] JV = CNT_W'(j);
    logic lead_bit;
    logic active;
    logic in_len;
    always_comb begin
      lead_bit = (JV & grp_mask) == '0;
      active   = (JV >> size) < count;
      in_len   = JV < byte_len;
      pred[j]  = lead_bit & active & in_len;
    end
  end

endmodule

// File: rtl/pg_flag_eval.sv
module pg_flag_eval #(
  parameter int VL_MAX  = 2048,
  localparam int VL_W   = $clog2(VL_MAX) + 1,
  localparam int PRED_W = VL_MAX / 8,
  localparam int IDX_W  = $clog2(PRED_W),
  localparam int CNT_W  = IDX_W + 1
) (
  input  logic [1:0]        size,
  input  logic [VL_W-1:0]   vl,
  input  logic [PRED_W-1:0] pred,
  output pg_pkg::nzcv_t     flags
);

  logic [IDX_W-1:0] last_idx;

  // Lowest predicate bit of the final element
  always_comb begin
    last_idx = IDX_W'(CNT_W'(vl >> 3) - (CNT_W'(1) << size));
  end

  always_comb begin
    flags.n = pred[0];
    flags.z = ~|pred;
    flags.c = ~pred[last_idx];
    flags.v = 1'b0;
  end

endmodule

// File: rtl/pred_pattern_gen.sv
module pred_pattern_gen #(
  parameter int VL_MAX  = 2048,
  localparam int VL_W   = $clog2(VL_MAX) + 1,
  localparam int PRED_W = VL_MAX / 8,
  localparam int CNT_W  = $clog2(PRED_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_size,
  input  logic [4:0]        in_pattern,
  input  logic [3:0]        in_dest,
  input  logic [VL_W-1:0]   in_vl,
  output logic              out_done,
  output logic [PRED_W-1:0] out_pred,
  output logic [3:0]        out_dest,
  output logic [3:0]        out_nzcv
);
  import pg_pkg::*;

  // Reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  logic [CNT_W-1:0]  elems_c, count_c;
  logic [PRED_W-1:0] pred_c;
  nzcv_t             flags_c;

  pg_count_decode #(.VL_MAX(VL_MAX)) u_dec (
    .size(in_size), .pattern(in_pattern), .vl(in_vl),
    .elems(elems_c), .count(count_c)
  );

  pg_mask_build #(.VL_MAX(VL_MAX)) u_mask (
    .size(in_size), .vl(in_vl), .count(count_c), .pred(pred_c)
  );

  pg_flag_eval #(.VL_MAX(VL_MAX)) u_flag (
    .size(in_size), .vl(in_vl), .pred(pred_c), .flags(flags_c)
  );

  // Next state
  logic [PRED_W-1:0] pred_d, pred_q;
  logic [3:0]        dest_d, dest_q, nzcv_d, nzcv_q;
  logic [CNT_W-1:0]  cnt_d, cnt_q, elems_d, elems_q;
  logic              done_d, done_q;

  always_comb begin
    done_d  = in_valid;
    pred_d  = pred_q;
    dest_d  = dest_q;
    nzcv_d  = nzcv_q;
    cnt_d   = cnt_q;
    elems_d = elems_q;
    if (in_valid) begin
      pred_d  = pred_c;
      dest_d  = in_dest;
      nzcv_d  = flags_c;
      cnt_d   = count_c;
      elems_d = elems_c;
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      done_q  <= 1'b0;
      pred_q  <= '0;
      dest_q  <= '0;
      nzcv_q  <= '0;
      cnt_q   <= '0;
      elems_q <= '0;
    end else begin
      done_q  <= done_d;
      pred_q  <= pred_d;
      dest_q  <= dest_d;
      nzcv_q  <= nzcv_d;
      cnt_q   <= cnt_d;
      elems_q <= elems_d;
    end
  end

  assign out_done = done_q;
  assign out_pred = pred_q;
  assign out_dest = dest_q;
  assign out_nzcv = nzcv_q;

  // R12: done pulse follows the strobe by one cycle
  a_r12_done_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_done);
  // R12: results hold while idle
  a_r12_hold_idle: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> (!out_done && $stable(out_pred) && $stable(out_nzcv)));
  // R4: decoded count never exceeds the element count
  a_r4_count_bounded: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_done |-> (cnt_q <= elems_q));
  // R10: Z agrees with the decoded count, which comes from separate logic
  a_r10_zero_matches_count: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_done |-> (out_nzcv[2] == (cnt_q == '0)));
  // R9: a true first element rules out an empty predicate
  a_r9_first_not_empty: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_nzcv[3] |-> !out_nzcv[2]);
  // R11: a true last element implies a true first element, since elements are contiguous
  a_r11_last_implies_first: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_done && !out_nzcv[1]) |-> out_nzcv[3]);
  // R2: the count of set bits equals the decoded count
  a_r2_popcount: assert property (@(posedge clk) disable iff (!rst_q_n)
    out_done |-> ($countones(out_pred) == int'(cnt_q)));

endmodule

// File: tb/sim_pred_pattern_gen.sv
module sim_pred_pattern_gen;

  localparam int PW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_size = '0;
  logic [4:0]    in_pattern = '0;
  logic [3:0]    in_dest = '0;
  logic [11:0]   in_vl = 12'd128;
  logic          out_done;
  logic [PW-1:0] out_pred;
  logic [3:0]    out_dest;
  logic [3:0]    out_nzcv;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  pred_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_size(in_size),
    .in_pattern(in_pattern), .in_dest(in_dest), .in_vl(in_vl),
    .out_done(out_done), .out_pred(out_pred), .out_dest(out_dest),
    .out_nzcv(out_nzcv)
  );

  function automatic int ref_count(int sz, int pat, int vl);
    int el = vl / (8 << sz);
    int req;
    if (pat >= 1 && pat <= 8) req = pat;
    else if (pat >= 9 && pat <= 13) req = 16 << (pat - 9);
    else req = -1;
    if (req > 0) return (req <= el) ? req : 0;
    case (pat)
      0: begin
        int p = 1;
        while (p * 2 <= el) p = p * 2;
        return p;
      end
      29: return (el / 4) * 4;
      30: return (el / 3) * 3;
      31: return el;
      default: return 0;
    endcase
  endfunction

  function automatic logic [PW-1:0] ref_pred(int sz, int cnt);
    logic [PW-1:0] p = '0;
    for (int e = 0; e < cnt; e++) p[e * (1 << sz)] = 1'b1;
    return p;
  endfunction

  function automatic string tag_of(int pat, int sz, int vl);
    int el = vl / (8 << sz);
    int req = (pat >= 1 && pat <= 8) ? pat : (pat >= 9 && pat <= 13) ? (16 << (pat - 9)) : 0;
    if (req > 0) return (req <= el) ? "R3" : "R4";
    if (pat == 0) return "R5";
    if (pat == 29 || pat == 30) return "R6";
    if (pat == 31) return "R7";
    return "R8";
  endfunction

  task automatic chk(string tag, string what, logic [PW-1:0] act, logic [PW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic run_one(int sz, int pat, int vl, int dst);
    int cnt = ref_count(sz, pat, vl);
    int el  = vl / (8 << sz);
    logic [PW-1:0] ep = ref_pred(sz, cnt);
    logic [PW-1:0] hi;
    logic [PW-1:0] held;
    @(negedge clk);
    in_valid = 1'b1; in_size = 2'(sz); in_pattern = 5'(pat);
    in_vl = 12'(vl); in_dest = 4'(dst);
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag_of(pat, sz, vl), "predicate", out_pred, ep);
    hi = ~('1 >> (PW - vl / 8)) ;
    if (vl / 8 == PW) hi = '0;
    chk("R2", "bits above VL/8", out_pred & hi, '0);
    chk("R1", "active count", PW'($countones(out_pred)), PW'(cnt));
    chk("R9", "N", PW'(out_nzcv[3]), PW'(cnt > 0));
    chk("R10", "Z", PW'(out_nzcv[2]), PW'(cnt == 0));
    chk("R11", "C", PW'(out_nzcv[1]), PW'(cnt != el));
    chk("R11", "V", PW'(out_nzcv[0]), '0);
    chk("R12", "dest", PW'(out_dest), PW'(dst));
    chk("R12", "done", PW'(out_done), PW'(1));
    held = out_pred;
    @(negedge clk);
    chk("R12", "done idle", PW'(out_done), '0);
    chk("R12", "hold idle", out_pred, held);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R12 watchdog expired: actual running expected finished");
    finish_run();
  end

  initial begin
    int seed = 32'h5eed_0123;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R13", "pred in reset", out_pred, '0);
    chk("R13", "done in reset", PW'(out_done), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R13", "pred after reset", out_pred, '0);
    chk("R13", "flags after reset", PW'(out_nzcv), '0);
    chk("R13", "dest after reset", PW'(out_dest), '0);

    // Directed corners
    run_one(0, 31, 2048, 1);   // R7 full word
    run_one(3, 2, 128, 2);     // R3 exact fit, last element true
    run_one(3, 3, 128, 3);     // R4 over the limit
    run_one(0, 13, 2048, 4);   // R3 256 elements
    run_one(0, 13, 1920, 5);   // R4 256 > 240
    run_one(0, 14, 512, 6);    // R8 unallocated
    run_one(2, 28, 512, 7);    // R8 unallocated
    run_one(0, 0, 384, 8);     // R5 48 -> 32
    run_one(3, 0, 128, 9);     // R5 2 -> 2
    run_one(3, 30, 128, 10);   // R6 MUL3 of 2 -> 0
    run_one(1, 29, 1152, 11);  // R6 MUL4 of 72
    run_one(1, 30, 1152, 12);  // R6 MUL3 of 72
    run_one(2, 31, 640, 13);   // R7 at word size
    run_one(1, 1, 128, 14);    // R3 single element

    // Random mix
    for (int i = 0; i < 500; i++) begin
      run_one(int'($urandom_range(3, 0)), int'($urandom_range(31, 0)),
              128 * int'($urandom_range(16, 1)), int'($urandom_range(15, 0)));
    end

    finish_run();
  end

endmodule